// File: doc/BRIEF.md
# Energy Detect Status Timer

This block keeps a single energy-present status bit for a PHY receiver. It raises a one-cycle event pulse whenever energy is judged to have appeared or disappeared, and that pulse feeds the interrupt flag logic. Three inputs can establish presence: a raw energy-detect level, a valid-link level and a level that is high while auto-negotiation is past its ability-detect state. All timing counts ticks of an external 1 ms strobe. The hold-off length is the parameter `HOLD_MS` (default 256), so a simulation can shrink it.

After reset the status reads 1 and a boot window opens. If nothing qualifying is seen within `HOLD_MS` ticks, the bit drops quietly. Once the bit is 1, the mode select decides what keeps it alive:

- In manual mode, raw energy or a valid link keeps the bit set.
- In auto-negotiation mode, raw energy or negotiation being past ability detect keeps the bit set.

When the keep condition is lost for `HOLD_MS` ticks, the removal pulse fires. The bit itself clears after a further `HOLD_MS` ticks. If the keep condition comes back during either wait, the wait is cancelled.

Top module: `energy_detect_status`

## Requirements
- R1: While reset is asserted and directly after it, `energy_on_o` is 1 and `energy_evt_o` is 0.
- R2: From reset, if none of raw energy, valid link or negotiation-past-ability is seen for `HOLD_MS` tick cycles, `energy_on_o` falls to 0 on the cycle after the last of those ticks, with no event pulse.
- R3: If any of the three presence inputs is high during the boot window, the boot timeout is cancelled: the bit stays 1 with no event pulse, however many ticks follow.
- R4: While the bit is 0, any one of the three presence inputs sets it to 1, and `energy_evt_o` is high for exactly the cycle in which the bit first reads 1.
- R5: While the bit is 1, the keep condition depends on the mode. With `manual_i`=1 it is raw energy OR valid link. With `manual_i`=0 it is raw energy OR negotiation-past-ability, and a valid link alone does not keep the bit.
- R6: After the keep condition goes low, the `HOLD_MS`-th tick later produces a one-cycle `energy_evt_o` pulse on the following cycle, while `energy_on_o` stays 1.
- R7: After the removal pulse, the `HOLD_MS`-th further tick clears `energy_on_o` on the following cycle, without a pulse.
- R8: If the keep condition returns during the removal wait or the clear wait, the wait is cancelled, the bit stays 1, no pulse is issued, and a later loss starts a full `HOLD_MS` count again.
- R9: The hold-off counter advances only in cycles where `ms_tick_i` is high; cycles without a tick have no effect on the timing.
- R10: `energy_evt_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| energy_raw_i | input | 1 | Raw energy-detect level |
| link_ok_i | input | 1 | Valid-link level |
| an_past_i | input | 1 | High while auto-negotiation is past ability detect |
| manual_i | input | 1 | 1 = manual mode, 0 = auto-negotiation mode |
| ms_tick_i | input | 1 | One-cycle 1 ms timing strobe |
| energy_on_o | output | 1 | Energy-present status bit |
| energy_evt_o | output | 1 | One-cycle appear/remove event pulse |

## Verification
A wrong state or count in this block shows up at the ports only as a pulse or a status edge landing on the wrong tick. That can be a pulse one tick early after a cancelled wait whose counter was not restarted, or a status that never clears because a wait state was skipped. The bench therefore compares both outputs on every cycle against a per-cycle expectation. Any such fault becomes visible no later than the tick on which the correct design would have acted. Mode faults are provoked by holding a valid link in auto-negotiation mode and confirming that the removal pulse still arrives on schedule.

// File: rtl/eds_pkg.sv
package eds_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_OFF,
        ST_ON,
        ST_LOSS,
        ST_DRAIN
    } eds_state_e;

    typedef struct packed {
        eds_state_e state;
        logic       on;
        logic       evt;
    } eds_regs_t;
endpackage

// File: rtl/eds_qualify.sv
module eds_qualify (
    input  logic energy_raw_i,
    input  logic link_ok_i,
    input  logic an_past_i,
    input  logic manual_i,
    output logic any_seen_o,
    output logic keep_o
);
    always_comb begin
        any_seen_o = energy_raw_i | link_ok_i | an_past_i;
        keep_o     = energy_raw_i | (manual_i ? link_ok_i : an_past_i);
    end
endmodule

// File: rtl/eds_hold_timer.sv
module eds_hold_timer #(
    parameter int HOLD_MS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(HOLD_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done_o = tick_i && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (done_o) cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(HOLD_MS)); // R9
    AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/energy_detect_status.sv
module energy_detect_status #(
    parameter int HOLD_MS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic energy_raw_i,
    input  logic link_ok_i,
    input  logic an_past_i,
    input  logic manual_i,
    input  logic ms_tick_i,
    output logic energy_on_o,
    output logic energy_evt_o
);
    import eds_pkg::*;

    eds_regs_t st_d, st_q;
    logic any_seen, keep, done, clr, counting;

    eds_qualify u_qual (
        .energy_raw_i (energy_raw_i),
        .link_ok_i    (link_ok_i),
        .an_past_i    (an_past_i),
        .manual_i     (manual_i),
        .any_seen_o   (any_seen),
        .keep_o       (keep)
    );

    eds_hold_timer #(.HOLD_MS(HOLD_MS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .tick_i (ms_tick_i),
        .done_o (done)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        unique case (st_q.state)
            ST_BOOT: begin
                if (any_seen) begin
                    st_d.state = ST_ON;
                end else if (done) begin
                    st_d.state = ST_OFF;
                    st_d.on    = 1'b0;
                end
            end
            ST_OFF: begin
                if (any_seen) begin
                    st_d.state = ST_ON;
                    st_d.on    = 1'b1;
                    st_d.evt   = 1'b1;
                end
            end
            ST_ON: begin
                if (!keep) st_d.state = ST_LOSS;
            end
            ST_LOSS: begin
                if (keep) begin
                    st_d.state = ST_ON;
                end else if (done) begin
                    st_d.state = ST_DRAIN;
                    st_d.evt   = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (keep) begin
                    st_d.state = ST_ON;
                end else if (done) begin
                    st_d.state = ST_OFF;
                    st_d.on    = 1'b0;
                end
            end
            default: st_d.state = ST_OFF;
        endcase
        counting = (st_q.state == ST_BOOT) || (st_q.state == ST_LOSS)
                || (st_q.state == ST_DRAIN);
        clr      = !counting || (st_d.state != st_q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_BOOT;
            st_q.on    <= 1'b1;
            st_q.evt   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign energy_on_o  = st_q.on;
    assign energy_evt_o = st_q.evt;

    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |=> !st_q.evt); // R10
    AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.on) |-> st_q.evt); // R4
    AST_FALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.on) |-> !st_q.evt); // R7
    AST_EVT_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.evt |-> st_q.on); // R6
    AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.on && keep) |=> st_q.on); // R5
endmodule

// File: tb/tb_energy_detect_status.sv
module tb_energy_detect_status;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e = 1'b0, l = 1'b0, a = 1'b0, m = 1'b1, t = 1'b0;
    logic on_o, evt_o;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic  on;
        logic  evt;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    energy_detect_status #(.HOLD_MS(HOLD)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .energy_raw_i (e),
        .link_ok_i    (l),
        .an_past_i    (a),
        .manual_i     (m),
        .ms_tick_i    (t),
        .energy_on_o  (on_o),
        .energy_evt_o (evt_o)
    );

    task automatic chk(input logic on_x, input logic evt_x, input string tag);
        n_chk++;
        if (on_o !== on_x || evt_o !== evt_x) begin
            n_fail++;
            $display("FAIL %s: on=%b evt=%b expected on=%b evt=%b",
                     tag, on_o, evt_o, on_x, evt_x);
        end
    endtask

    // driver: apply one cycle of inputs, queue the outputs expected after the edge
    task automatic step(input logic ie, input logic il, input logic ia, input logic im,
                        input logic it, input logic on_x, input logic evt_x,
                        input string tag);
        exp_t item;
        @(negedge clk);
        e = ie; l = il; a = ia; m = im; t = it;
        item.on = on_x; item.evt = evt_x; item.tag = tag;
        q.push_back(item);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            chk(it.on, it.evt, it.tag);
        end
    end

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        e = 0; l = 0; a = 0; m = 1; t = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        e = 0; l = 0; a = 0; m = 1; t = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(1'b1, 1'b0, "R1 in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: on=%b evt=%b expected completion", on_o, evt_o);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(posedge clk); #2;
        chk(1'b1, 1'b0, "R1 after reset");

        // R2 + R9: boot timeout, with idle cycles between ticks
        for (int i = 0; i < HOLD - 1; i++) begin
            step(0,0,0,1,1, 1,0, "R2 boot tick");
            step(0,0,0,1,0, 1,0, "R9 idle cycle");
            step(0,0,0,1,0, 1,0, "R9 idle cycle");
        end
        step(0,0,0,1,1, 0,0, "R2 boot expiry");
        step(0,0,0,1,0, 0,0, "R2 stays off");

        // R4 via energy, then R6/R7 in manual mode
        step(1,0,0,1,0, 1,1, "R4 set by energy");
        step(1,0,0,1,0, 1,0, "R10 pulse single");
        step(0,0,0,1,0, 1,0, "R6 loss starts");
        for (int i = 0; i < HOLD - 1; i++) step(0,0,0,1,1, 1,0, "R6 waiting");
        step(0,0,0,1,1, 1,1, "R6 removal pulse");
        step(0,0,0,1,0, 1,0, "R10 pulse single");
        for (int i = 0; i < HOLD - 1; i++) step(0,0,0,1,1, 1,0, "R7 drain wait");
        step(0,0,0,1,1, 0,0, "R7 cleared");

        // R4 via link; R8 cancel and full restart; R5 manual keep by link
        step(0,1,0,1,0, 1,1, "R4 set by link");
        step(0,1,0,1,1, 1,0, "R5 link keeps in manual");
        step(0,0,0,1,0, 1,0, "R8 loss starts");
        step(0,0,0,1,1, 1,0, "R8 wait");
        step(0,0,0,1,1, 1,0, "R8 wait");
        step(0,1,0,1,0, 1,0, "R8 link back cancels");
        step(0,0,0,1,0, 1,0, "R8 loss again");
        for (int i = 0; i < HOLD - 1; i++) step(0,0,0,1,1, 1,0, "R8 full recount");
        step(0,0,0,1,1, 1,1, "R6 removal pulse");
        step(0,0,0,1,1, 1,0, "R8 drain wait");
        step(0,0,0,1,1, 1,0, "R8 drain wait");
        step(0,1,0,1,0, 1,0, "R8 drain cancel");
        for (int i = 0; i < HOLD + 1; i++) step(0,1,0,1,1, 1,0, "R8 held after cancel");

        // R5: auto mode, link alone does not keep the bit
        step(0,1,0,0,0, 1,0, "R5 auto loss starts");
        for (int i = 0; i < HOLD - 1; i++) step(0,1,0,0,1, 1,0, "R5 waiting");
        step(0,1,0,0,1, 1,1, "R5 pulse despite link");
        step(0,1,1,0,0, 1,0, "R8 neg-past cancels drain");
        for (int i = 0; i < HOLD + 1; i++) step(0,0,1,0,1, 1,0, "R5 neg-past keeps");
        step(0,0,0,0,0, 1,0, "R6 auto loss");
        for (int i = 0; i < HOLD - 1; i++) step(0,0,0,0,1, 1,0, "R6 waiting");
        step(0,0,0,0,1, 1,1, "R6 removal pulse");
        for (int i = 0; i < HOLD - 1; i++) step(0,0,0,0,1, 1,0, "R7 drain wait");
        step(0,0,0,0,1, 0,0, "R7 cleared");
        step(0,0,1,0,0, 1,1, "R4 set by neg-past");
        step(0,0,1,0,0, 1,0, "R10 pulse single");
        drain();

        // R3: presence during boot cancels the timeout
        do_reset();
        step(1,0,0,1,0, 1,0, "R3 energy in boot");
        for (int i = 0; i < HOLD + 2; i++) step(1,0,0,1,1, 1,0, "R3 no timeout");
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule